// File: doc/BRIEF.md
# Peripheral Register Access Sequencer

The sequencer turns one CPU-side request (read or write, byte or word, with a 16-bit address) into the bus states needed by an internal bank of peripheral registers. An address-decode table of four windows tells it how wide the target register is (8 or 16 bits) and whether a bus cycle lasts two or three states. It then drives address, read strobe, write strobe and write data for the right number of states. It returns read data together with a one-cycle done pulse.

A word access that lands on an 8-bit register is split into two byte cycles. The first cycle goes to the even address and carries the high byte. The second goes to the odd address and carries the low byte. A byte access to a 16-bit register, or a word access at an odd address, never reaches the bus: it is answered at once with an error flag.

The state machine has four states. IDLE waits for a request; an accepted legal request moves to T1. T1 always moves to T2. T2 moves to T3 when the cycle is three-state. Otherwise T2 is the final state: it returns to T1 when a second byte cycle is still owed, or to IDLE when the request is complete. T3 ends a three-state cycle and follows the same choice between T1 and IDLE. An illegal request stays in IDLE.

Top module: `periph_access_seq`

## Requirements
- R1: The register width and state count come from four address windows, each with an inclusive base and limit, a wide bit and a slow bit. The defaults are: window 0 FF00–FF3F (16-bit, three-state), window 1 FF40–FF7F (16-bit, two-state), window 2 FF80–FFBF (8-bit, three-state), window 3 FF80–FFFF (8-bit, two-state). Where windows overlap, the lowest index wins. An address outside every window is treated as an 8-bit register with three states.
- R2: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. A two-state bus cycle occupies exactly two clocks: T1, then T2. `bus_active` is high in both.
- R3: A three-state bus cycle occupies exactly three clocks: T1, T2, T3.
- R4: Within a bus cycle, no strobe is raised in T1. `bus_rd` (reads) or `bus_wr` (writes) is high from T2 to the end of the cycle, and the two strobes are never high together. `bus_addr` does not change while a strobe is high.
- R5: A word access to an 8-bit register runs two bus cycles. The first uses the even request address and carries bits 15:8. The second uses the address plus one and carries bits 7:0. Byte data travels on lane bits 7:0 of `bus_wdata`/`bus_rdata`. Read bytes are assembled with the first byte in `resp_rdata[15:8]`.
- R6: A word access to a 16-bit register at an even address runs one bus cycle with all 16 data bits on the bus.
- R7: A byte access to an 8-bit register is allowed at any address parity. It runs one bus cycle on lane bits 7:0. Read data is returned zero-extended.
- R8: A byte access to a 16-bit register, or a word access at an odd address, raises no bus activity. It produces `resp_done` and `resp_err` together on the clock after acceptance, with `resp_rdata` zero.
- R9: `resp_done` is a one-clock pulse on the clock after the final state of the last bus cycle. For a legal request it arrives (cycles × states + 1) clocks after acceptance. `resp_rdata` is valid while `resp_done` is high and is zero for writes.
- R10: A request presented while `busy` is high is ignored. It neither changes the running access nor starts a later one.
- R11: After reset the block is idle: `busy`, `bus_active`, both strobes and `resp_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word size, 0 = byte size |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| busy | output | 1 | Access in progress; requests are ignored |
| resp_done | output | 1 | One-clock completion pulse |
| resp_err | output | 1 | Request rejected (with resp_done) |
| resp_rdata | output | 16 | Read result, valid with resp_done |
| bus_active | output | 1 | Bus cycle in progress, address valid |
| bus_addr | output | 16 | Peripheral bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 16 | Write data on the peripheral bus |
| bus_rdata | input | 16 | Read data from the peripheral bus |

## Verification
Counting from the accepting edge, the done pulse is due at the falling edge numbered (cycles × states + 1): 3 for a two-state single cycle, 4 for a three-state one, 5 and 7 for split words, and 1 for a rejected request. Every scenario task drives its request one falling edge before the accepting edge. It then samples the outputs on each following falling edge, recording active clocks, strobe clocks, strobe addresses and write lanes, and compares the edge index of the done pulse with that count. Read data comes from a bench model that derives each byte from the bus address, so the order of split bytes is visible in the result.

// File: rtl/pas_pkg.sv
package pas_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3
    } bus_state_e;

    typedef struct packed {
        logic wide;
        logic slow;
    } reg_attr_t;

endpackage

// File: rtl/pas_decode.sv
module pas_decode
    import pas_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_WIN = 4,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE  = {16'hFF80, 16'hFF80, 16'hFF40, 16'hFF00},
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LIMIT = {16'hFFFF, 16'hFFBF, 16'hFF7F, 16'hFF3F},
    parameter logic [NUM_WIN-1:0] WIN_WIDE  = 4'b0011,
    parameter logic [NUM_WIN-1:0] WIN_SLOW  = 4'b0101,
    parameter logic DFLT_WIDE = 1'b0,
    parameter logic DFLT_SLOW = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_attr_t         attr
);

    logic [NUM_WIN-1:0] hit;

    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
        assign hit[gi] = (addr >= WIN_BASE[gi]) && (addr <= WIN_LIMIT[gi]);
    end

    // R1: walk from highest to lowest index so the lowest matching window wins
    always_comb begin
        attr.wide = DFLT_WIDE;
        attr.slow = DFLT_SLOW;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                attr.wide = WIN_WIDE[i];
                attr.slow = WIN_SLOW[i];
            end
        end
    end

endmodule

// File: rtl/pas_fsm.sv
module pas_fsm
    import pas_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       bad,
    input  logic       slow,
    input  logic       split,
    output bus_state_e state,
    output logic       half,
    output logic       last,
    output logic       done,
    output logic       err
);

    bus_state_e state_q, state_d;
    logic       slow_q, split_q, half_q, done_q, err_q;
    logic       more;
    logic       go;
    logic       reject;

    assign go     = (state_q == ST_IDLE) && start && !bad;
    assign reject = (state_q == ST_IDLE) && start && bad;
    assign last   = (state_q == ST_T3) || ((state_q == ST_T2) && !slow_q);
    assign more   = split_q && !half_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = go ? ST_T1 : ST_IDLE;
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = slow_q ? ST_T3 : (more ? ST_T1 : ST_IDLE);
            ST_T3:   state_d = more ? ST_T1 : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // attribute and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slow_q  <= 1'b0;
            split_q <= 1'b0;
            half_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (go) begin
                slow_q  <= slow;
                split_q <= split;
                half_q  <= 1'b0;
            end else if (last && more) begin
                half_q  <= 1'b1;
            end
            done_q <= reject || (last && !more);
            err_q  <= reject;
        end
    end

    assign state = state_q;
    assign half  = half_q;
    assign done  = done_q;
    assign err   = err_q;

    // R8: a rejected request never leaves IDLE
    p_reject_stays_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (state_q == ST_IDLE));

    // R3: a three-state cycle always passes through T3 after T2
    p_slow_reaches_t3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T2 && slow_q) |=> (state_q == ST_T3));

endmodule

// File: rtl/pas_datapath.sv
module pas_datapath
    import pas_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wide,
    input  bus_state_e        state,
    input  logic              half,
    input  logic              last,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_active,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int LANE_W = DATA_W / 2;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              write_q, wide_q, word_q;
    logic              split_q, strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            wide_q  <= 1'b0;
            word_q  <= 1'b0;
        end else if (start) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
            wide_q  <= wide;
            word_q  <= req_word;
        end
    end

    assign split_q    = word_q && !wide_q;
    assign bus_active = (state != ST_IDLE);
    assign strobe     = (state == ST_T2) || (state == ST_T3);
    assign bus_rd     = strobe && !write_q;
    assign bus_wr     = strobe && write_q;
    assign bus_addr   = bus_active ? (addr_q + ADDR_W'(half)) : '0;

    always_comb begin
        bus_wdata = '0;
        if (bus_active && write_q) begin
            if (wide_q)       bus_wdata = wdata_q;
            else if (split_q) bus_wdata = {{LANE_W{1'b0}}, half ? wdata_q[LANE_W-1:0]
                                                                : wdata_q[DATA_W-1:LANE_W]};
            else              bus_wdata = {{LANE_W{1'b0}}, wdata_q[LANE_W-1:0]};
        end
    end

    // read data is captured at the end of the last state of each bus cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (start) begin
            rdata_q <= '0;
        end else if (last && !write_q) begin
            if (wide_q)       rdata_q <= bus_rdata;
            else if (!split_q) rdata_q <= {{LANE_W{1'b0}}, bus_rdata[LANE_W-1:0]};
            else if (!half)   rdata_q[DATA_W-1:LANE_W] <= bus_rdata[LANE_W-1:0];
            else              rdata_q[LANE_W-1:0]      <= bus_rdata[LANE_W-1:0];
        end
    end

    assign rdata = rdata_q;

    // R4: address held while a strobe is up
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> $stable(bus_addr));

    // R4: a strobe only rises after an active state without strobe (T1)
    p_strobe_after_t1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_rd) || $rose(bus_wr)) |-> $past(bus_active));

endmodule

// File: rtl/periph_access_seq.sv
module periph_access_seq
    import pas_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int NUM_WIN = 4,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE  = {16'hFF80, 16'hFF80, 16'hFF40, 16'hFF00},
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LIMIT = {16'hFFFF, 16'hFFBF, 16'hFF7F, 16'hFF3F},
    parameter logic [NUM_WIN-1:0] WIN_WIDE  = 4'b0011,
    parameter logic [NUM_WIN-1:0] WIN_SLOW  = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              resp_done,
    output logic              resp_err,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              bus_active,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    reg_attr_t  attr;
    bus_state_e state;
    logic       half, last;
    logic       start, bad, split;

    pas_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_WIN  (NUM_WIN),
        .WIN_BASE (WIN_BASE),
        .WIN_LIMIT(WIN_LIMIT),
        .WIN_WIDE (WIN_WIDE),
        .WIN_SLOW (WIN_SLOW)
    ) u_decode (
        .addr(req_addr),
        .attr(attr)
    );

    assign busy  = (state != ST_IDLE);
    assign start = req_valid && !busy;
    assign bad   = req_word ? req_addr[0] : attr.wide;
    assign split = req_word && !attr.wide;

    pas_fsm u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .bad  (bad),
        .slow (attr.slow),
        .split(split),
        .state(state),
        .half (half),
        .last (last),
        .done (resp_done),
        .err  (resp_err)
    );

    pas_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_datapath (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_write (req_write),
        .req_word  (req_word),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .wide      (attr.wide),
        .state     (state),
        .half      (half),
        .last      (last),
        .bus_rdata (bus_rdata),
        .bus_active(bus_active),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .rdata     (resp_rdata)
    );

    // R9: completion is only reported once the bus is released
    p_done_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |-> !busy && !bus_active);

    // R8: an error always comes with done and empty read data
    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> resp_done && (resp_rdata == '0));

    // R4: the two strobes never overlap
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

endmodule

// File: tb/periph_access_seq_test.sv
module periph_access_seq_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        busy, resp_done, resp_err, bus_active, bus_rd, bus_wr;
    logic [15:0] resp_rdata, bus_addr, bus_wdata, bus_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // peripheral model: high byte = low address byte ^ 5A, low byte = low address byte
    assign bus_rdata = {bus_addr[7:0] ^ 8'h5A, bus_addr[7:0]};

    periph_access_seq uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .resp_done(resp_done), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .bus_active(bus_active), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // one request; samples every falling edge after the accepting edge
    task automatic access(input string tag, input bit wr, input bit word, input logic [15:0] a,
                          input logic [15:0] w, input int cycles, input bit slow, input bit wide,
                          input bit exp_err, input logic [15:0] exp_rd, input bit inject);
        int n_act = 0, n_stb = 0, bad_dir = 0, done_at = 0, states;
        logic [15:0] a_first = '0, a_last = '0, w_first = '0, w_last = '0, rd_got = '0;
        logic [15:0] ew_first, ew_last;
        bit err_got = 0;
        states = slow ? 3 : 2;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = word; req_addr = a; req_wdata = w;
        for (int n = 1; n <= 30; n++) begin
            @(negedge clk);
            if (n == 1) req_valid = 1'b0;
            if (bus_active) n_act++;
            if (bus_rd || bus_wr) begin
                if (n_stb == 0) begin a_first = bus_addr; w_first = bus_wdata; end
                a_last = bus_addr; w_last = bus_wdata;
                n_stb++;
                if (bus_wr != wr) bad_dir++;
            end
            if (inject && n == 2) begin
                req_valid = 1'b1; req_write = !wr; req_word = 1'b0; req_addr = 16'hFFC1; req_wdata = 16'h00EE;
            end
            if (inject && n == 3) req_valid = 1'b0;
            if (resp_done) begin
                done_at = n; rd_got = resp_rdata; err_got = resp_err;
                break;
            end
        end
        check(done_at == (exp_err ? 1 : cycles * states + 1), {tag, " R9 done timing"}, done_at,
              exp_err ? 1 : cycles * states + 1);
        check(err_got == exp_err, {tag, " R8 error flag"}, err_got, exp_err);
        check(rd_got == exp_rd, {tag, " R9 read data"}, rd_got, exp_rd);
        if (exp_err) begin
            check(n_act == 0 && n_stb == 0, {tag, " R8 no bus activity"}, n_act, 0);
        end else begin
            check(n_act == cycles * states, slow ? {tag, " R3 active states"} : {tag, " R2 active states"},
                  n_act, cycles * states);
            check(n_stb == cycles * (states - 1), {tag, " R4 strobe states"}, n_stb, cycles * (states - 1));
            check(bad_dir == 0, {tag, " R4 strobe direction"}, bad_dir, 0);
            check(a_first == a, {tag, " first address"}, a_first, a);
            check(a_last == ((cycles == 2) ? a + 16'd1 : a), {tag, " R5 last address"}, a_last,
                  (cycles == 2) ? a + 16'd1 : a);
            if (wr) begin
                ew_first = wide ? w : (cycles == 2 ? {8'h00, w[15:8]} : {8'h00, w[7:0]});
                ew_last  = wide ? w : {8'h00, w[7:0]};
                check(w_first == ew_first, {tag, " write lane first"}, w_first, ew_first);
                check(w_last == ew_last, {tag, " write lane last"}, w_last, ew_last);
            end
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(!busy && !bus_active && !bus_rd && !bus_wr && !resp_done, "R11 reset idle",
              {busy, bus_active, bus_rd, bus_wr, resp_done}, 0);
    endtask

    task automatic test_wide_regs();
        access("R6 W0 read",  0, 1, 16'hFF10, 16'h0000, 1, 1, 1, 0, {8'h10 ^ 8'h5A, 8'h10}, 0);
        access("R6 W0 write", 1, 1, 16'hFF12, 16'hA1B2, 1, 1, 1, 0, 16'h0000, 0);
        access("R6 W1 read",  0, 1, 16'hFF44, 16'h0000, 1, 0, 1, 0, {8'h44 ^ 8'h5A, 8'h44}, 0);
        access("R6 W1 write", 1, 1, 16'hFF46, 16'hC3D4, 1, 0, 1, 0, 16'h0000, 0);
    endtask

    task automatic test_split_regs();
        access("R5 W2 read",  0, 1, 16'hFFA0, 16'h0000, 2, 1, 0, 0, 16'hA0A1, 0);
        access("R5 W2 write", 1, 1, 16'hFFA2, 16'h1234, 2, 1, 0, 0, 16'h0000, 0);
        access("R5 W3 read",  0, 1, 16'hFFC4, 16'h0000, 2, 0, 0, 0, 16'hC4C5, 0);
        access("R5 W3 write", 1, 1, 16'hFFC6, 16'hBEEF, 2, 0, 0, 0, 16'h0000, 0);
    endtask

    task automatic test_bytes();
        access("R7 odd read",  0, 0, 16'hFFC3, 16'h0000, 1, 0, 0, 0, 16'h00C3, 0);
        access("R7 odd write", 1, 0, 16'hFF91, 16'h5577, 1, 1, 0, 0, 16'h0000, 0);
    endtask

    task automatic test_decode();
        access("R1 overlap low", 0, 0, 16'hFF80, 16'h0000, 1, 1, 0, 0, 16'h0080, 0);
        access("R1 edge FFBF",   0, 0, 16'hFFBF, 16'h0000, 1, 1, 0, 0, 16'h00BF, 0);
        access("R1 edge FFC0",   0, 0, 16'hFFC0, 16'h0000, 1, 0, 0, 0, 16'h00C0, 0);
        access("R1 unmatched",   0, 1, 16'h1000, 16'h0000, 2, 1, 0, 0, 16'h0001, 0);
    endtask

    task automatic test_errors();
        access("R8 byte to wide", 0, 0, 16'hFF10, 16'h0000, 1, 1, 1, 1, 16'h0000, 0);
        access("R8 odd word wr",  1, 1, 16'hFFC5, 16'h9999, 1, 0, 0, 1, 16'h0000, 0);
        access("R8 odd word rd",  0, 1, 16'hFF11, 16'h0000, 1, 1, 1, 1, 16'h0000, 0);
    endtask

    task automatic test_busy();
        int stray = 0;
        access("R10 busy ignored", 0, 1, 16'hFFA0, 16'h0000, 2, 1, 0, 0, 16'hA0A1, 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (bus_active || resp_done) stray++;
        end
        check(stray == 0, "R10 no late start", stray, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_wide_regs();
        test_split_regs();
        test_bytes();
        test_decode();
        test_errors();
        test_busy();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule